// File: doc/BRIEF.md
# Two-stage SPI clock prescaler

This block produces the serial clock of an SPI host from the fast main clock. Two counters run in series. A predivider emits one tick every `2 << div_sel` main-clock cycles. A half-period counter then counts `rate + 1` of those ticks between transitions of the serial clock. The serial clock period is therefore `2 * (rate + 1) * (2 << div_sel)` main-clock cycles, and the duty cycle is 50%.

The shift logic of the host does not watch the serial clock itself. It uses two strobes, each one main-clock cycle wide. The leading strobe marks a transition away from the idle level and the trailing strobe marks a return to it. The divider settings and the polarity are captured only while the block is disabled. Each enable starts the serial clock from its idle level. A rate value below the legal floor is raised to that floor, so the serial clock can never exceed its top legal frequency.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: The predivider ticks once every `2 << div_sel` main-clock cycles, with `div_sel` a 2-bit value from 0 to 3 (2, 4, 8 or 16 cycles).
- R2: The serial clock changes level on every (`rate` + 1)-th predivider tick. After the first rising clock edge that samples `en` = 1, the k-th transition appears on the output at edge k × `(2 << div_sel)` × (`rate` + 1), counted from that edge as edge 1.
- R3: A `rate` value from 0 to 3 behaves exactly like `rate` = 4.
- R4: After reset the captured settings are `div_sel` = 0, `rate` = 4 and polarity 0. If `en` is already high when reset is released, those values are used: a transition every 10 cycles, whatever the inputs show.
- R5: When an edge samples `en` = 0, or during reset, the serial clock takes the `cpol` level sampled at that edge and both strobes are 0.
- R6: `div_sel`, `rate` and `cpol` are captured only at edges that sample `en` = 0. Changing them while the block is enabled leaves the running serial clock unchanged.
- R7: `lead_stb` is high for exactly the one cycle in which the serial clock has just moved away from the captured polarity. `trail_stb` is high for exactly the one cycle in which it has just returned to that polarity.
- R8: Every enable restarts the sequence from the idle level, so the first strobe after an enable is always `lead_stb`. This holds even when the previous enable ended with the clock away from idle.
- R9: `lead_stb` and `trail_stb` are never high together, and two strobes are always at least 10 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the serial clock; settings are captured while low |
| div_sel | input | 2 | Predivider select, divide by 2 << div_sel |
| rate | input | 6 | Half-period length in predivider ticks, minus one |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on a transition away from idle |
| trail_stb | output | 1 | One-cycle strobe on a transition back to idle |

## Verification
The bench uses the default parameters: a 2-bit predivider select, a 6-bit rate field and a rate floor of 4. These defaults make the whole predivider range reachable, from divide-by-2 up to divide-by-16. Together with rate 63 they give the slowest setting, 1024 main cycles per half period, and the bench measures two full half periods at that setting. Because the floor is 4, rate values 0 and 3 exercise the clamp, and a rate of 4 with divide-by-2 gives the 10-cycle minimum strobe spacing that R9 relies on.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;

    localparam int CK_DIV_W  = 2;
    localparam int CK_RATE_W = 6;
    localparam int CK_PRE_W  = 1 << CK_DIV_W;

    typedef struct packed {
        logic [CK_DIV_W-1:0]  div;
        logic [CK_RATE_W-1:0] rate;
        logic                 pol;
    } clk_cfg_t;

    typedef enum logic [1:0] {
        EDGE_NONE  = 2'd0,
        EDGE_LEAD  = 2'd1,
        EDGE_TRAIL = 2'd2
    } edge_kind_t;

    // terminal count of the predivider: (2 << d) - 1, i.e. bits 0..d set
    function automatic logic [CK_PRE_W-1:0] pre_last(input logic [CK_DIV_W-1:0] d);
        logic [CK_PRE_W-1:0] r;
        for (int i = 0; i < CK_PRE_W; i++) begin
            r[i] = (i <= int'(d));
        end
        return r;
    endfunction

    function automatic logic [CK_RATE_W-1:0] clamp_rate(input logic [CK_RATE_W-1:0] r,
                                                        input int floor_val);
        return (int'(r) < floor_val) ? CK_RATE_W'(floor_val) : r;
    endfunction

endpackage

// File: rtl/spi_cfg_hold.sv
module spi_cfg_hold
    import spi_clkgen_pkg::*;
#(
    parameter int RATE_MIN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CK_DIV_W-1:0]  div_in,
    input  logic [CK_RATE_W-1:0] rate_in,
    input  logic                 pol_in,
    output clk_cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.div  <= '0;
            cfg.rate <= CK_RATE_W'(RATE_MIN);
            cfg.pol  <= 1'b0;
        end else if (!en) begin
            cfg.div  <= div_in;
            cfg.rate <= clamp_rate(rate_in, RATE_MIN);
            cfg.pol  <= pol_in;
        end
    end

endmodule

// File: rtl/spi_prediv.sv
module spi_prediv
    import spi_clkgen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [CK_DIV_W-1:0] div,
    output logic                tick
);

    logic [CK_PRE_W-1:0] cnt;
    logic                at_end;

    assign at_end = (cnt == pre_last(div));
    assign tick   = en && at_end;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_halfdiv.sv
module spi_halfdiv
    import spi_clkgen_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    input  logic [CK_RATE_W-1:0] rate,
    output logic                 flip
);

    logic [CK_RATE_W-1:0] cnt;

    assign flip = tick && (cnt == rate);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == rate) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_sclk_out.sv
module spi_sclk_out
    import spi_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic flip,
    input  logic pol_run,
    input  logic pol_idle,
    output logic sclk,
    output logic lead_stb,
    output logic trail_stb
);

    edge_kind_t kind_d;
    edge_kind_t kind_q;

    always_comb begin
        kind_d = EDGE_NONE;
        if (en && flip) begin
            kind_d = (sclk == pol_run) ? EDGE_LEAD : EDGE_TRAIL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sclk   <= pol_idle;
            kind_q <= EDGE_NONE;
        end else begin
            kind_q <= kind_d;
            if (flip) begin
                sclk <= ~sclk;
            end
        end
    end

    assign lead_stb  = (kind_q == EDGE_LEAD);
    assign trail_stb = (kind_q == EDGE_TRAIL);

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
    import spi_clkgen_pkg::*;
#(
    parameter int RATE_MIN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [CK_DIV_W-1:0]  div_sel,
    input  logic [CK_RATE_W-1:0] rate,
    input  logic                 cpol,
    output logic                 sclk,
    output logic                 lead_stb,
    output logic                 trail_stb
);

    clk_cfg_t cfg;
    logic     pre_tick;
    logic     half_flip;

    spi_cfg_hold #(.RATE_MIN(RATE_MIN)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .div_in  (div_sel),
        .rate_in (rate),
        .pol_in  (cpol),
        .cfg     (cfg)
    );

    spi_prediv u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .div  (cfg.div),
        .tick (pre_tick)
    );

    spi_halfdiv u_half (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (pre_tick),
        .rate (cfg.rate),
        .flip (half_flip)
    );

    spi_sclk_out u_out (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .flip      (half_flip),
        .pol_run   (cfg.pol),
        .pol_idle  (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cpol,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb
);

    logic any_stb;
    assign any_stb = lead_stb || trail_stb;

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(lead_stb && trail_stb));

    p_gap_r9: assert property (@(posedge clk) disable iff (rst)
        any_stb |-> !$past(any_stb) && !$past(any_stb, 2) && !$past(any_stb, 3) && !$past(any_stb, 4));

    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (sclk == $past(cpol)) && !any_stb);

    p_strobe_on_change_r7: assert property (@(posedge clk) disable iff (rst)
        any_stb |-> (sclk != $past(sclk)));

    p_change_has_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst) && (sclk != $past(sclk))) |-> any_stb);

    p_single_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        any_stb |=> !any_stb);

endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cpol      (cpol),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
);

// File: tb/sim_spi_sclk_prescaler.sv
module sim_spi_sclk_prescaler;

    typedef struct {
        longint cyc;
        bit     lead;
        bit     lvl;
        string  tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [5:0] rate = 6'd4;
    logic       cpol = 1'b0;
    logic       sclk;
    logic       lead_stb;
    logic       trail_stb;

    longint cyc = 0;
    int     checks = 0;
    int     fails = 0;
    exp_t   sb[$];

    spi_sclk_prescaler u0 (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .div_sel   (div_sel),
        .rate      (rate),
        .cpol      (cpol),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && (lead_stb || trail_stb)) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6", "unexpected strobe at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.cyc, e.tag, "strobe cycle", cyc, e.cyc);
                check(lead_stb == e.lead, "R8", "lead strobe kind", lead_stb, e.lead);
                check(sclk == e.lvl, "R7", "sclk level at strobe", sclk, e.lvl);
                check(!(lead_stb && trail_stb), "R9", "both strobes", 1, 0);
            end
        end
    end

    task automatic push_run(input longint c0, input int p, input int h, input bit pol,
                            input int ntog, input string tag);
        for (int k = 1; k <= ntog; k++) begin
            exp_t e;
            e.cyc  = c0 + longint'(k) * p * h;
            e.lead = (k % 2) == 1;
            e.lvl  = pol ^ e.lead;
            e.tag  = tag;
            sb.push_back(e);
        end
    endtask

    task automatic drain(input longint deadline, input string tag);
        while (sb.size() != 0 && cyc <= deadline) @(negedge clk);
        check(sb.size() == 0, tag, "missing strobes", sb.size(), 0);
        sb.delete();
    endtask

    task automatic run(input int d, input int r, input bit pol, input int ntog,
                       input bit change, input string tag);
        int     p;
        int     h;
        longint c0;
        @(negedge clk);
        en = 1'b0;
        div_sel = d[1:0];
        rate = r[5:0];
        cpol = pol;
        repeat (2) @(negedge clk);
        check(sclk == pol, "R5", "idle level", sclk, pol);
        check(!lead_stb && !trail_stb, "R5", "idle strobes", lead_stb, 0);
        p = 2 << d;
        h = ((r < 4) ? 4 : r) + 1;
        c0 = cyc;
        en = 1'b1;
        push_run(c0, p, h, pol, ntog, tag);
        if (change) begin
            repeat (3) @(negedge clk);
            div_sel = ~div_sel;
            rate = 6'd63;
            cpol = ~pol;
        end
        drain(c0 + longint'(ntog) * p * h + 2, tag);
        // no extra strobe for a little while (monitor flags any)
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(sclk == cpol, "R5", "level after disable", sclk, cpol);
        check(!lead_stb && !trail_stb, "R5", "strobes after disable", trail_stb, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        longint c0;
        // R4: enable held through reset, inputs ask for the slowest setting
        en = 1'b1;
        div_sel = 2'd3;
        rate = 6'd63;
        cpol = 1'b0;
        repeat (3) @(negedge clk);
        check(sclk == 1'b0, "R5", "reset sclk", sclk, 0);
        check(!lead_stb && !trail_stb, "R5", "reset strobes", lead_stb, 0);
        c0 = cyc;
        rst = 1'b0;
        push_run(c0, 2, 5, 1'b0, 3, "R4");
        drain(c0 + 32, "R4");

        run(0, 4, 1'b0, 4, 1'b0, "R1");   // R1: fastest predivider
        run(1, 7, 1'b0, 4, 1'b0, "R2");   // R2: divide 4, rate 7
        run(2, 0, 1'b0, 3, 1'b0, "R3");   // R3: clamp of rate 0
        run(0, 3, 1'b1, 4, 1'b0, "R3");   // R3: clamp of rate 3, idle high
        run(3, 63, 1'b1, 2, 1'b0, "R1");  // R1: divide 16 at top rate
        run(1, 9, 1'b0, 3, 1'b1, "R6");   // R6: inputs change while running
        run(2, 5, 1'b1, 3, 1'b0, "R8");   // R8: restart after odd count

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule